// File: doc/BRIEF.md
# Pipelined Up/Down Step Counter

This block is a synchronous binary counter whose width and step size are fixed at elaboration. On every rising edge where the enable input is high, the count either grows or shrinks by the step value, depending on a direction bit. Alternatively, the count can be overwritten in parallel from a data input when a load strobe is given.

The load strobe, the load data and the direction bit are not applied directly. They first pass through an input register stage, in the same way as the operand registers in front of a multiply-accumulate slice. The enable input gates every register, so latency is counted in enabled edges.

- A load or direction value sampled on one enabled edge acts on the count at the next enabled edge. That is the second enabled edge, counting the one that sampled it.
- The number of register stages on that path is a parameter, with a default of two.
- Arithmetic wraps silently modulo 2^WIDTH.

Top module: `step_updown_counter`

## Requirements
- R1: While `rst` is high on a rising edge, `count` becomes 0 and every pipeline stage is cleared. This happens whatever the state of `en`.
- R2: When the pipelined direction bit is 1 and no load is pending, each enabled edge adds the step to `count`.
- R3: When the pipelined direction bit is 0 and no load is pending, each enabled edge subtracts the step from `count`.
- R4: A change on `countUp` first affects the counting at the second enabled edge, counting the edge that sampled it. The update at the sampling edge still uses the previous direction.
- R5: A `loadReq` sampled high with `loadVal` on an enabled edge sets `count` to that `loadVal` at the second enabled edge. At the sampling edge itself, `count` is updated by stepping as usual.
- R6: When a pipelined load reaches the output stage, it wins over stepping in that cycle.
- R7: On an edge where `en` is low, `count` and all pipeline stages keep their values. Strobes presented only during such edges are ignored, and latency is counted in enabled edges only.
- R8: Addition and subtraction wrap modulo 2^WIDTH with no flag. For example, 0 minus the step gives 2^WIDTH minus the step.
- R9: Only the low WIDTH bits of the 48-bit STEP parameter are used as the step.
- R10: A load that is still in the pipeline when reset is applied never reaches `count`. After reset, the pipelined direction reads 0 (count down).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for all registers |
| loadReq | input | 1 | Parallel load strobe, pipelined |
| loadVal | input | WIDTH | Value to load, pipelined with `loadReq` |
| countUp | input | 1 | Direction: 1 counts up, 0 counts down; pipelined |
| count | output | WIDTH | Counter value |

## Verification
`count` is registered, so every check samples it at the falling edge that follows the rising edge under test. A `loadReq` or `countUp` value therefore shows in `count` at the falling edge after the next enabled rising edge. The value visible half a cycle after the sampling edge still reflects the old pipeline contents.

The bench keeps its own one-stage model of the input pipeline and advances it only on edges where `en` is high, so stalled cycles stretch the expected latency exactly as they should. Directed steps check the exact half-cycle point on each side of the latency boundary. A full sweep of all load values and a long pseudo-random stream of enable, load, direction and reset then compare against the model on every cycle.

// File: rtl/stpcnt_pkg.sv
package stpcnt_pkg;

  // Strobes passed from the control pipeline to the datapath each cycle.
  typedef struct packed {
    logic clear;     // synchronous clear of every register
    logic shift;     // advance the pipeline and update the count
    logic takeLoad;  // pipelined load has reached the output stage
    logic stepUp;    // pipelined direction: 1 add, 0 subtract
  } cntStrobe_t;

endpackage

// File: rtl/stpcnt_ctrl.sv
module stpcnt_ctrl
  import stpcnt_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       loadReq,
  input  logic       countUp,
  output cntStrobe_t strobe
);

  localparam int STAGES = LAT - 1;

  logic [STAGES-1:0] loadPipe;
  logic [STAGES-1:0] dirPipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          loadPipe <= '0;
          dirPipe  <= '0;
        end else if (en) begin
          loadPipe <= loadReq;
          dirPipe  <= countUp;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          loadPipe <= '0;
          dirPipe  <= '0;
        end else if (en) begin
          loadPipe <= {loadPipe[STAGES-2:0], loadReq};
          dirPipe  <= {dirPipe[STAGES-2:0], countUp};
        end
      end
    end
  endgenerate

  always_comb begin
    strobe.clear    = rst;
    strobe.shift    = en;
    strobe.takeLoad = loadPipe[STAGES-1];
    strobe.stepUp   = dirPipe[STAGES-1];
  end

endmodule

// File: rtl/stpcnt_dpath.sv
module stpcnt_dpath
  import stpcnt_pkg::*;
#(
  parameter int          WIDTH = 48,
  parameter logic [47:0] STEP  = 48'h1,
  parameter int          LAT   = 2
) (
  input  logic             clk,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count
);

  localparam int               STAGES = LAT - 1;
  localparam logic [WIDTH-1:0] STEPW  = STEP[WIDTH-1:0];

  logic [WIDTH-1:0] dataPipe [STAGES];
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] nextCount;

  // Load data travels alongside the load strobe.
  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      for (int i = 0; i < STAGES; i++) dataPipe[i] <= '0;
    end else if (strobe.shift) begin
      dataPipe[0] <= loadVal;
      for (int i = 1; i < STAGES; i++) dataPipe[i] <= dataPipe[i-1];
    end
  end

  always_comb begin
    stepped   = strobe.stepUp ? (count + STEPW) : (count - STEPW);
    nextCount = strobe.takeLoad ? dataPipe[STAGES-1] : stepped;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)      count <= '0;
    else if (strobe.shift) count <= nextCount;
  end

endmodule

// File: rtl/step_updown_counter.sv
module step_updown_counter
  import stpcnt_pkg::*;
#(
  parameter int          WIDTH = 48,
  parameter logic [47:0] STEP  = 48'h1,
  parameter int          LAT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             loadReq,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             countUp,
  output logic [WIDTH-1:0] count
);

  cntStrobe_t strobe;

  stpcnt_ctrl #(.LAT(LAT)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .loadReq (loadReq),
    .countUp (countUp),
    .strobe  (strobe)
  );

  stpcnt_dpath #(.WIDTH(WIDTH), .STEP(STEP), .LAT(LAT)) u_dpath (
    .clk     (clk),
    .strobe  (strobe),
    .loadVal (loadVal),
    .count   (count)
  );

endmodule

// File: rtl/stpcnt_chk.sv
module stpcnt_chk #(
  parameter int          WIDTH = 48,
  parameter logic [47:0] STEP  = 48'h1,
  parameter int          LAT   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             loadReq,
  input logic [WIDTH-1:0] loadVal,
  input logic             countUp,
  input logic [WIDTH-1:0] count
);

  localparam int               STAGES = LAT - 1;
  localparam logic [WIDTH-1:0] STEPW  = STEP[WIDTH-1:0];

  // Independent shadow of the input pipeline, built from the ports.
  logic             shLoad [STAGES];
  logic             shDir  [STAGES];
  logic [WIDTH-1:0] shData [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) begin
        shLoad[i] <= 1'b0;
        shDir[i]  <= 1'b0;
        shData[i] <= '0;
      end
    end else if (en) begin
      shLoad[0] <= loadReq;
      shDir[0]  <= countUp;
      shData[0] <= loadVal;
      for (int i = 1; i < STAGES; i++) begin
        shLoad[i] <= shLoad[i-1];
        shDir[i]  <= shDir[i-1];
        shData[i] <= shData[i-1];
      end
    end
  end

  logic             tailLoad;
  logic             tailDir;
  logic [WIDTH-1:0] tailData;
  assign tailLoad = shLoad[STAGES-1];
  assign tailDir  = shDir[STAGES-1];
  assign tailData = shData[STAGES-1];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> count == '0);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  // R5
  load_land_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && tailLoad) |=> count == $past(tailData));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && !tailLoad && tailDir) |=> count == $past(count) + STEPW);

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && !tailLoad && !tailDir) |=> count == $past(count) - STEPW);

endmodule

bind step_updown_counter stpcnt_chk #(.WIDTH(WIDTH), .STEP(STEP), .LAT(LAT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .loadReq (loadReq),
  .loadVal (loadVal),
  .countUp (countUp),
  .count   (count)
);

// File: tb/sim_step_updown_counter.sv
`timescale 1ns/1ps
module sim_step_updown_counter;

  localparam int          TW      = 8;
  localparam logic [47:0] TB_STEP = 48'h0000_0120_0005;
  localparam logic [7:0]  STEPLO  = TB_STEP[7:0];   // R9: low bits only

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          loadReq = 1'b0;
  logic [TW-1:0] loadVal = '0;
  logic          countUp = 1'b0;
  logic [TW-1:0] count;

  int  vectors = 0;
  int  errors  = 0;
  bit  done    = 1'b0;

  // bench model of the one-stage input pipeline and the count
  logic [7:0] mCount = '0;
  logic       mPl = 1'b0;
  logic       mPd = 1'b0;
  logic [7:0] mPdata = '0;

  always #10 clk = ~clk;   // 50 MHz

  step_updown_counter #(.WIDTH(TW), .STEP(TB_STEP), .LAT(2)) u0 (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .loadReq (loadReq),
    .loadVal (loadVal),
    .countUp (countUp),
    .count   (count)
  );

  task automatic cyc(input logic e, input logic l, input logic [7:0] d, input logic u);
    en = e; loadReq = l; loadVal = d; countUp = u;
    @(posedge clk);
    if (rst) begin
      mCount = '0; mPl = 1'b0; mPd = 1'b0; mPdata = '0;
    end else if (e) begin
      mCount = mPl ? mPdata : (mPd ? mCount + STEPLO : mCount - STEPLO);
      mPl = l; mPd = u; mPdata = d;
    end
    @(negedge clk);
  endtask

  task automatic expectv(input logic [7:0] exp, input string tag);
    vectors++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s count=%h expected=%h", tag, count, exp);
    end
  endtask

  task automatic expectModel(input string tag);
    expectv(mCount, tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    @(negedge clk);
    rst = 1'b1;
    cyc(1'b0, 1'b0, 8'h00, 1'b0);
    cyc(1'b1, 1'b1, 8'h5A, 1'b1);
    expectv(8'h00, "R1 reset clears count");
    rst = 1'b0;

    cyc(1'b1, 1'b0, 8'h00, 1'b1);
    expectv(8'hFB, "R8 wrap down from zero (R10 dir resets to down)");
    cyc(1'b1, 1'b0, 8'h00, 1'b1);
    expectv(8'h00, "R8 wrap up to zero");
    cyc(1'b1, 1'b1, 8'h40, 1'b1);
    expectv(8'h05, "R5 load not yet visible");
    cyc(1'b1, 1'b0, 8'h00, 1'b1);
    expectv(8'h40, "R5 load lands on second edge");
    cyc(1'b1, 1'b0, 8'h00, 1'b0);
    expectv(8'h45, "R2 R4 up step, new direction not yet used");
    expectv(8'h45, "R9 step uses low bits only");
    cyc(1'b1, 1'b0, 8'h00, 1'b0);
    expectv(8'h40, "R3 R4 down step after latency");
    cyc(1'b1, 1'b1, 8'h10, 1'b0);
    expectv(8'h3B, "R3 down step");
    cyc(1'b1, 1'b0, 8'h00, 1'b0);
    expectv(8'h10, "R6 load wins over down step");
    cyc(1'b1, 1'b1, 8'h77, 1'b1);
    expectv(8'h0B, "R3 step before stall");
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, 8'h00, 1'b0);
      expectv(8'h0B, "R7 hold while disabled");
    end
    cyc(1'b1, 1'b0, 8'h00, 1'b0);
    expectv(8'h77, "R7 latency counted in enabled edges");
    cyc(1'b0, 1'b1, 8'h22, 1'b1);
    cyc(1'b0, 1'b1, 8'h22, 1'b1);
    expectv(8'h77, "R7 hold with strobes while disabled");
    cyc(1'b1, 1'b0, 8'h00, 1'b1);
    expectv(8'h72, "R7 disabled load ignored");
    cyc(1'b1, 1'b1, 8'h99, 1'b1);
    expectv(8'h77, "R2 up step");
    rst = 1'b1;
    cyc(1'b1, 1'b0, 8'h00, 1'b1);
    expectv(8'h00, "R1 reset mid-run");
    rst = 1'b0;
    cyc(1'b1, 1'b0, 8'h00, 1'b1);
    expectv(8'hFB, "R10 flushed load not applied");

    // every load value
    for (int v = 0; v < 256; v++) begin
      cyc(1'b1, 1'b1, 8'(v), 1'b1);
      cyc(1'b1, 1'b0, 8'h00, v[0]);
      expectv(8'(v), "R5 load sweep");
    end

    // pseudo-random stream against the model
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rst = (lfsr[5:0] == 6'd0);
      cyc(lfsr[3:1] != 3'd0, lfsr[8:7] == 2'd0, lfsr[15:8], lfsr[11]);
      expectModel("R2 R3 R6 R7 R8 random stream");
    end
    rst = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired count=%h expected=%h", count, mCount);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule